// File: doc/BRIEF.md
# Charge Pump Fastlock Timer Controller

This block decides which of two charge pump current codes a frequency synthesizer control path drives. Normally the primary code is used. When software writes the divider-counter word with its gain bit set, the block stores that bit. If the boost feature is enabled, the stored bit switches the output to the secondary code, so that a new frequency settles faster.

Two exit policies are available and a mode input selects between them. In manual mode the boost lasts until software writes the gain bit back to 0. In timed mode a counter advances on each phase-detector event tick. After a programmed number of ticks it clears the stored gain bit by itself, and the primary code returns. A power-down or counter-reset input sends the timer back to its load state and cancels the boost.

Top module: `cp_boost_ctrl`

## Requirements
- R1: After reset the stored gain bit is 0, the busy flag is 0 and the output code equals the primary code.
- R2: While the enable input is 0, the busy flag is 0 and the output code is the primary code, whatever the stored gain bit holds.
- R3: A write strobe stores the written gain bit at the next clock edge. With the enable input at 1 and a stored gain bit of 1, the busy flag is 1 and the output code equals the secondary code.
- R4: With the mode input at 0 (manual), a stored gain bit of 1 stays 1 until a write, a power-down or a counter reset changes it. Event ticks have no effect on it.
- R5: With the mode input at 1 (timed), the stored gain bit clears at the clock edge that samples the (timeout_code+1)*4-th event tick counted after the write that set it. The limit therefore runs from 4 ticks (code 0) to 64 ticks (code 15).
- R6: The timer advances only in a cycle where the enable input is 1, the mode input is 1, the stored gain bit is 1 and a tick is present. In any other cycle it holds its count.
- R7: A write strobe resets the tick count to zero, so a repeated write of 1 restarts the full timeout. A tick in the same cycle as a write is not counted.
- R8: A power-down or counter-reset input clears the stored gain bit and the tick count at the next edge, and it takes priority over a write in the same cycle.
- R9: A write of gain bit 0 ends the boost at the next edge in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boost_en_i | input | 1 | Boost feature enable |
| timed_mode_i | input | 1 | Exit policy: 0 manual, 1 timed |
| timeout_code_i | input | 4 | Timeout selector; limit is (code+1)*4 ticks |
| cur_primary_i | input | 3 | Steady-state current code |
| cur_secondary_i | input | 3 | Boost current code |
| ncnt_wr_i | input | 1 | Divider-counter word write strobe |
| ncnt_gain_i | input | 1 | Gain bit carried by the write |
| pfd_tick_i | input | 1 | Phase-detector event tick, one cycle per event |
| pwr_down_i | input | 1 | Power-down request; forces the load state |
| cnt_reset_i | input | 1 | Counter reset request; forces the load state |
| cur_code_o | output | 3 | Active current code |
| gain_bit_o | output | 1 | Stored gain bit |
| boost_busy_o | output | 1 | Secondary current is active |

## Verification
The assertions take the control inputs (enable, mode, timeout code) as static register values that change only between events. A ticking timer is never checked across a change of the timeout code. They also take every input as settled before each rising edge, and a tick as a single-cycle pulse. The stimulus drives all inputs on the falling edge and holds the timeout code steady while a timed boost is running. Only the timed-mode directed case switches the mode while the counter is held, and it does so to show that the counter holds. The random phase draws new static settings only after a forced clear has emptied the timer.

// File: rtl/cp_boost_pkg.sv
package cp_boost_pkg;

  typedef enum logic {
    EXIT_MANUAL = 1'b0,
    EXIT_TIMED  = 1'b1
  } exit_mode_e;

  typedef struct packed {
    logic force_clr;
    logic load;
    logic value;
    logic expire;
  } gain_cmd_t;

endpackage

// File: rtl/cp_boost_rst_sync.sv
module cp_boost_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cp_boost_timer.sv
module cp_boost_timer #(
  parameter int TC_W  = 4,
  parameter int SCALE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_i,
  input  logic            restart_i,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [TC_W-1:0] code_i,
  output logic            expire_o
);
  localparam int MAX_LIM = (2 ** TC_W) * SCALE;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, lim;
  logic             cnt_en;

  always_comb begin
    lim     = CNT_W'((32'(code_i) + 1) * SCALE);
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    cnt_en   = 1'b0;
    if (force_i || restart_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (run_i && tick_i) begin
      cnt_en = 1'b1;
      if (cnt_inc >= lim) begin
        cnt_d    = '0;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6: no tick counted outside a running cycle
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_i && !restart_i && !(run_i && tick_i)) |=> $stable(cnt_q));

  // R7 / R8: restart and force empty the count
  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i || restart_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cp_boost_gain.sv
module cp_boost_gain
  import cp_boost_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  gain_cmd_t cmd_i,
  output logic      gain_o
);
  logic gain_q, gain_d, gain_en;

  always_comb begin
    gain_d  = gain_q;
    gain_en = 1'b0;
    if (cmd_i.force_clr) begin
      gain_d  = 1'b0;
      gain_en = 1'b1;
    end else if (cmd_i.load) begin
      gain_d  = cmd_i.value;
      gain_en = 1'b1;
    end else if (cmd_i.expire) begin
      gain_d  = 1'b0;
      gain_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= 1'b0;
    else if (gain_en) gain_q <= gain_d;
  end

  assign gain_o = gain_q;

  assert_force_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.force_clr |=> !gain_q);

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.load && !cmd_i.force_clr) |=> (gain_q == $past(cmd_i.value)));
endmodule

// File: rtl/cp_boost_select.sv
module cp_boost_select #(
  parameter int CODE_W = 3
) (
  input  logic              boost_i,
  input  logic [CODE_W-1:0] prim_i,
  input  logic [CODE_W-1:0] sec_i,
  output logic [CODE_W-1:0] code_o
);
  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    assign code_o[b] = boost_i ? sec_i[b] : prim_i[b];
  end
endmodule

// File: rtl/cp_boost_ctrl.sv
module cp_boost_ctrl
  import cp_boost_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int TC_W   = 4,
  parameter int SCALE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boost_en_i,
  input  logic              timed_mode_i,
  input  logic [TC_W-1:0]   timeout_code_i,
  input  logic [CODE_W-1:0] cur_primary_i,
  input  logic [CODE_W-1:0] cur_secondary_i,
  input  logic              ncnt_wr_i,
  input  logic              ncnt_gain_i,
  input  logic              pfd_tick_i,
  input  logic              pwr_down_i,
  input  logic              cnt_reset_i,
  output logic [CODE_W-1:0] cur_code_o,
  output logic              gain_bit_o,
  output logic              boost_busy_o
);
  logic       rst_s_n;
  logic       force_clr, timer_run, expire, boost;
  exit_mode_e mode;
  gain_cmd_t  cmd;

  cp_boost_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  always_comb begin
    mode      = exit_mode_e'(timed_mode_i);
    force_clr = pwr_down_i | cnt_reset_i;
    timer_run = boost_en_i & (mode == EXIT_TIMED) & gain_bit_o;
    boost     = boost_en_i & gain_bit_o;
    cmd.force_clr = force_clr;
    cmd.load      = ncnt_wr_i;
    cmd.value     = ncnt_gain_i;
    cmd.expire    = expire;
  end

  cp_boost_timer #(.TC_W(TC_W), .SCALE(SCALE)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .force_i(force_clr), .restart_i(ncnt_wr_i),
    .run_i(timer_run), .tick_i(pfd_tick_i), .code_i(timeout_code_i),
    .expire_o(expire)
  );

  cp_boost_gain u_gain (
    .clk(clk), .rst_n(rst_s_n), .cmd_i(cmd), .gain_o(gain_bit_o)
  );

  cp_boost_select #(.CODE_W(CODE_W)) u_sel (
    .boost_i(boost), .prim_i(cur_primary_i), .sec_i(cur_secondary_i),
    .code_o(cur_code_o)
  );

  assign boost_busy_o = boost;

  assert_disabled_primary_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !boost_en_i |-> (cur_code_o == cur_primary_i && !boost_busy_o));

  assert_manual_hold_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (gain_bit_o && !timed_mode_i && !ncnt_wr_i && !force_clr) |=> gain_bit_o);

  assert_expire_clears_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    expire |=> !gain_bit_o);

  assert_zero_write_ends_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ncnt_wr_i && !ncnt_gain_i) |=> !boost_busy_o);
endmodule

// File: tb/sim_cp_boost_ctrl.sv
module sim_cp_boost_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, mode = 1'b0;
  logic [3:0] tcode = 4'd0;
  logic [2:0] prim = 3'd2, sec = 3'd5;
  logic       wr = 1'b0, wgain = 1'b0, tick = 1'b0, pd = 1'b0, crst = 1'b0;
  logic [2:0] code;
  logic       gbit, busy;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_gain = 0;
  int m_ticks = 0;

  always #4 clk = ~clk;

  cp_boost_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .boost_en_i(en), .timed_mode_i(mode),
    .timeout_code_i(tcode), .cur_primary_i(prim), .cur_secondary_i(sec),
    .ncnt_wr_i(wr), .ncnt_gain_i(wgain), .pfd_tick_i(tick),
    .pwr_down_i(pd), .cnt_reset_i(crst),
    .cur_code_o(code), .gain_bit_o(gbit), .boost_busy_o(busy)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gain  = 0;
      m_ticks = 0;
    end else if (pd || crst) begin
      m_gain  = 0;
      m_ticks = 0;
    end else if (wr) begin
      m_gain  = wgain ? 1 : 0;
      m_ticks = 0;
    end else if (en && mode && m_gain == 1 && tick) begin
      m_ticks++;
      if (m_ticks >= (int'(tcode) + 1) * 4) begin
        m_gain  = 0;
        m_ticks = 0;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int eb;
    eb = (en && m_gain == 1) ? 1 : 0;
    check("gain_bit", int'(gbit), m_gain);
    check("busy", int'(busy), eb);
    check("code", int'(code), eb == 1 ? int'(sec) : int'(prim));
  endtask

  // one cycle: compare at falling edge, then drive the next inputs
  task automatic cyc(logic w, logic g, logic t, logic p, logic c);
    @(negedge clk);
    compare();
    wr = w; wgain = g; tick = t; pd = p; crst = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 1, 0, 0);
      for (int j = 0; j < gap; j++) cyc(0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    idle(4);
    check("reset gain", int'(gbit), 0);
    check("reset code", int'(code), 2);

    // R2: stored gain with enable low
    cur_req = "R2";
    en = 0; mode = 1; tcode = 0;
    cyc(1, 1, 0, 0, 0);
    ticks(10, 0);
    idle(1);
    check("disabled busy", int'(busy), 0);
    check("disabled gain stays (R6 no count)", int'(gbit), 1);
    cyc(1, 0, 0, 0, 0);

    // R3/R4: manual mode
    cur_req = "R3";
    en = 1; mode = 0; tcode = 0;
    cyc(1, 1, 0, 0, 0);
    idle(1);
    check("boost code", int'(code), 5);
    cur_req = "R4";
    ticks(100, 0);
    idle(1);
    check("manual still busy", int'(busy), 1);
    cur_req = "R9";
    cyc(1, 0, 0, 0, 0);
    idle(1);
    check("zero write ends", int'(busy), 0);

    // R5: timed expiry at several codes and tick spacings
    cur_req = "R5";
    mode = 1; tcode = 0;
    cyc(1, 1, 0, 0, 0);
    ticks(3, 0);
    idle(1);
    check("code0 before limit", int'(busy), 1);
    ticks(1, 0);
    idle(1);
    check("code0 expired", int'(busy), 0);
    tcode = 15;
    cyc(1, 1, 0, 0, 0);
    ticks(63, 2);
    check("code15 before limit", int'(gbit), 1);
    ticks(1, 2);
    check("code15 expired", int'(gbit), 0);
    tcode = 5;
    cyc(1, 1, 0, 0, 0);
    ticks(24, 1);
    idle(2);

    // R7: restart
    cur_req = "R7";
    tcode = 1;
    cyc(1, 1, 0, 0, 0);
    ticks(6, 0);
    cyc(1, 1, 1, 0, 0);
    ticks(7, 0);
    idle(1);
    check("restarted still busy", int'(busy), 1);
    ticks(1, 0);
    idle(1);
    check("restarted expired", int'(busy), 0);

    // R6: mode switched away holds the count
    cur_req = "R6";
    tcode = 0;
    cyc(1, 1, 0, 0, 0);
    ticks(2, 0);
    mode = 0;
    ticks(5, 0);
    mode = 1;
    ticks(1, 0);
    idle(1);
    check("held count", int'(gbit), 1);
    ticks(1, 0);
    idle(1);
    check("held count expires", int'(gbit), 0);

    // R8: forced load state
    cur_req = "R8";
    cyc(1, 1, 0, 0, 0);
    idle(2);
    cyc(0, 0, 0, 1, 0);
    idle(1);
    check("power-down clears", int'(gbit), 0);
    cyc(1, 1, 0, 0, 1);
    idle(1);
    check("reset beats write", int'(gbit), 0);
    cyc(1, 1, 0, 0, 0);
    ticks(2, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(1, 1, 0, 0, 0);
    ticks(3, 0);
    idle(1);
    check("count emptied by reset", int'(gbit), 1);

    // random phase
    cur_req = "R5";
    for (int k = 0; k < 3000; k++) begin
      if (k % 200 == 0) begin
        cyc(0, 0, 0, 0, 1);
        en = 1'($urandom_range(0, 3) != 0);
        mode = 1'($urandom);
        tcode = 4'($urandom_range(0, 3));
        prim = 3'($urandom); sec = 3'($urandom);
      end else begin
        cyc(1'($urandom_range(0, 15) == 0), 1'($urandom_range(0, 3) != 0),
            1'($urandom), 1'($urandom_range(0, 60) == 0), 1'b0);
      end
    end
    idle(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule